// File: doc/BRIEF.md
# Bidirectional Parity Bus Transceiver

This block connects two 8-bit data ports, A and B, and passes data between them in one of two directions. A direction input selects transmit (A to B) or receive (B to A). An active-low enable releases both data ports when high. A parity pin goes with the data. When transmitting, the block generates the parity bit from the A data and drives it out. When receiving, the pin is an input, and the block checks the B data against it. An active-low error flag reports a mismatch.

An odd/even select sets the parity sense. The whole path is combinational: there is no clock and no storage. Each port that can drive has a data-out bus and an output-enable. The surrounding logic uses these to build the tri-state net.

Top module: `pbx_transceiver`

## Requirements
- R1: With `oe_n` = 0 and `dir_tx` = 1 (transmit), `b_oe` = 1, `a_oe` = 0 and `b_out` equals `a_in`.
- R2: With `oe_n` = 0 and `dir_tx` = 0 (receive), `a_oe` = 1, `b_oe` = 0 and `a_out` equals `b_in`.
- R3: With `oe_n` = 1, `a_oe`, `b_oe` and `par_oe` are all 0, whatever the direction.
- R4: `par_out` gives a total count of ones over `a_in` and `par_out` that is odd when `odd_sel` = 1 and even when `odd_sel` = 0. For example, with even sense and five ones on A, `par_out` = 1.
- R5: `par_oe` = 1 exactly when `oe_n` = 0 and `dir_tx` = 1.
- R6: In receive (`dir_tx` = 0), `err_n` = 0 exactly when the count of ones over `b_in` and `par_in` does not match the sense from `odd_sel` (1 = odd, 0 = even). For example, with odd sense, `par_in` = 1 and three ones on B, `err_n` = 0.
- R7: In transmit (`dir_tx` = 1), `err_n` = 1 for every data value, sense and `par_in` level, and whether `oe_n` is 0 or 1.
- R8: In receive, the check of R6 also holds while `oe_n` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dir_tx | input | 1 | 1 = transmit A to B, 0 = receive B to A |
| oe_n | input | 1 | Active-low enable; high releases both ports |
| odd_sel | input | 1 | Parity sense: 1 = odd, 0 = even |
| a_in | input | 8 | Level seen on port A |
| a_out | output | 8 | Value driven onto port A |
| a_oe | output | 1 | Drive enable for port A |
| b_in | input | 8 | Level seen on port B |
| b_out | output | 8 | Value driven onto port B |
| b_oe | output | 1 | Drive enable for port B |
| par_in | input | 1 | Level seen on the parity pin |
| par_out | output | 1 | Generated parity bit |
| par_oe | output | 1 | Drive enable for the parity pin |
| err_n | output | 1 | Active-low parity error flag |

## Verification
All 256 data values are applied in each combination of direction, sense and enable level. This catches any single data bit missing from the parity tree or from the forwarding path. In receive, each value is also tried with the parity pin at both levels. This separates a checker that ignores the received bit from one that folds it in with the wrong polarity. Sweeping the enable high in both directions separates the port release from the parity checker, which must keep working while the ports are released.

// File: rtl/pbx_pkg.sv
package pbx_pkg;

    localparam int unsigned PBX_WIDTH = 8;

    typedef enum logic {
        DIR_RX = 1'b0,
        DIR_TX = 1'b1
    } pbx_dir_e;

    typedef enum logic {
        SENSE_EVEN = 1'b0,
        SENSE_ODD  = 1'b1
    } pbx_sense_e;

    typedef struct packed {
        logic a_en;
        logic b_en;
        logic p_en;
    } pbx_drive_s;

    // Bit that makes the word plus itself carry the requested sense.
    function automatic logic pbx_fill_bit(input logic word_xor, input pbx_sense_e sense);
        return word_xor ^ (sense == SENSE_ODD);
    endfunction

endpackage

// File: rtl/pbx_parity_tree.sv
module pbx_parity_tree #(
    parameter int unsigned WIDTH = pbx_pkg::PBX_WIDTH
) (
    input  logic [WIDTH-1:0] data,
    output logic             xor_out
);
    localparam int unsigned LVLS = $clog2(WIDTH);
    localparam int unsigned PADW = 1 << LVLS;

    logic [PADW-1:0] stage [LVLS+1];

    assign stage[0] = {{(PADW-WIDTH){1'b0}}, data};

    for (genvar l = 0; l < LVLS; l++) begin : g_lvl
        localparam int unsigned N = PADW >> (l + 1);
        for (genvar i = 0; i < N; i++) begin : g_node
            assign stage[l+1][i] = stage[l][2*i] ^ stage[l][2*i+1];
        end
        if (N < PADW) begin : g_pad
            assign stage[l+1][PADW-1:N] = '0;
        end
    end

    assign xor_out = stage[LVLS][0];
endmodule

// File: rtl/pbx_drive_ctrl.sv
module pbx_drive_ctrl
    import pbx_pkg::*;
(
    input  pbx_dir_e   dir,
    input  logic       oe_n,
    output pbx_drive_s drv
);
    always_comb begin
        drv = '0;
        if (!oe_n) begin
            unique case (dir)
                DIR_TX: begin
                    drv.b_en = 1'b1;
                    drv.p_en = 1'b1;
                end
                DIR_RX: drv.a_en = 1'b1;
                default: drv = '0;
            endcase
        end
    end
endmodule

// File: rtl/pbx_err_detect.sv
module pbx_err_detect
    import pbx_pkg::*;
(
    input  pbx_dir_e   dir,
    input  pbx_sense_e sense,
    input  logic       word_xor,
    input  logic       par_bit,
    output logic       err_n
);
    logic mismatch;

    assign mismatch = (word_xor ^ par_bit) != (sense == SENSE_ODD);
    assign err_n    = (dir == DIR_TX) ? 1'b1 : !mismatch;
endmodule

// File: rtl/pbx_transceiver.sv
module pbx_transceiver
    import pbx_pkg::*;
#(
    parameter int unsigned WIDTH = PBX_WIDTH
) (
    input  logic             dir_tx,
    input  logic             oe_n,
    input  logic             odd_sel,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe,
    input  logic             par_in,
    output logic             par_out,
    output logic             par_oe,
    output logic             err_n
);
    pbx_dir_e   dir;
    pbx_sense_e sense;
    pbx_drive_s drv;
    logic       a_xor;
    logic       b_xor;

    assign dir   = pbx_dir_e'(dir_tx);
    assign sense = pbx_sense_e'(odd_sel);

    pbx_drive_ctrl u_drv (
        .dir  (dir),
        .oe_n (oe_n),
        .drv  (drv)
    );

    pbx_parity_tree #(.WIDTH(WIDTH)) u_tree_a (
        .data    (a_in),
        .xor_out (a_xor)
    );

    pbx_parity_tree #(.WIDTH(WIDTH)) u_tree_b (
        .data    (b_in),
        .xor_out (b_xor)
    );

    pbx_err_detect u_chk (
        .dir      (dir),
        .sense    (sense),
        .word_xor (b_xor),
        .par_bit  (par_in),
        .err_n    (err_n)
    );

    assign b_out   = a_in;
    assign a_out   = b_in;
    assign a_oe    = drv.a_en;
    assign b_oe    = drv.b_en;
    assign par_oe  = drv.p_en;
    assign par_out = pbx_fill_bit(a_xor, sense);
endmodule

// File: rtl/pbx_transceiver_chk.sv
module pbx_transceiver_chk #(
    parameter int unsigned WIDTH = 8
) (
    input logic             dir_tx,
    input logic             oe_n,
    input logic             odd_sel,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] a_out,
    input logic             a_oe,
    input logic [WIDTH-1:0] b_in,
    input logic [WIDTH-1:0] b_out,
    input logic             b_oe,
    input logic             par_in,
    input logic             par_out,
    input logic             par_oe,
    input logic             err_n
);
    always_comb begin
        // R1
        tx_fwd_chk: assert (oe_n || !dir_tx || (b_oe && !a_oe && b_out == a_in));
        // R2
        rx_fwd_chk: assert (oe_n || dir_tx || (a_oe && !b_oe && a_out == b_in));
        // R3
        hiz_chk: assert (!oe_n || !(a_oe || b_oe || par_oe));
        // R4
        par_gen_chk: assert (($countones({a_in, par_out}) % 2) == int'(odd_sel));
        // R5
        par_oe_chk: assert (par_oe == (!oe_n && dir_tx));
        // R6
        rx_err_chk: assert (dir_tx ||
            (err_n == (($countones({b_in, par_in}) % 2) == int'(odd_sel))));
        // R7
        tx_err_chk: assert (!dir_tx || err_n);
        // R1
        one_drv_chk: assert ($onehot0({a_oe, b_oe}));
    end
endmodule

bind pbx_transceiver pbx_transceiver_chk #(.WIDTH(WIDTH)) u_chk_bind (.*);

// File: tb/pbx_transceiver_tb.sv
module pbx_transceiver_tb;
    localparam int unsigned W = 8;

    logic         clk = 1'b0;
    logic         dir_tx, oe_n, odd_sel, par_in;
    logic [W-1:0] a_in, b_in;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe, par_out, par_oe, err_n;

    int unsigned n_vec  = 0;
    int unsigned n_miss = 0;
    bit          done   = 1'b0;

    always #2.5 clk = ~clk;

    pbx_transceiver #(.WIDTH(W)) u_dut (
        .dir_tx (dir_tx), .oe_n (oe_n), .odd_sel (odd_sel),
        .a_in (a_in), .a_out (a_out), .a_oe (a_oe),
        .b_in (b_in), .b_out (b_out), .b_oe (b_oe),
        .par_in (par_in), .par_out (par_out), .par_oe (par_oe),
        .err_n (err_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_miss++;
            $display("FAIL %s: actual %0h expected %0h (dir=%0b oe_n=%0b odd=%0b a=%0h b=%0h p=%0b)",
                     req, act, exp, dir_tx, oe_n, odd_sel, a_in, b_in, par_in);
        end
    endtask

    function automatic int ones(input logic [W-1:0] v);
        int c = 0;
        for (int i = 0; i < W; i++) c += int'(v[i]);
        return c;
    endfunction

    task automatic apply(input logic d, input logic en_n, input logic od,
                         input logic [W-1:0] av, input logic [W-1:0] bv, input logic p);
        @(negedge clk);
        dir_tx = d; oe_n = en_n; odd_sel = od; a_in = av; b_in = bv; par_in = p;
        @(posedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_miss++;
            n_vec++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
            $finish;
        end
    end

    initial begin
        // quiescent state: enable released
        apply(1'b1, 1'b1, 1'b0, '0, '0, 1'b0);
        chk("R3 idle a_oe", a_oe, 0);
        chk("R3 idle b_oe", b_oe, 0);
        chk("R3 idle par_oe", par_oe, 0);
        chk("R7 idle err_n", err_n, 1);

        // worked examples
        apply(1'b1, 1'b0, 1'b0, 8'h1F, 8'h00, 1'b0);
        chk("R4 even five ones", par_out, 1);
        apply(1'b0, 1'b0, 1'b1, 8'h00, 8'h07, 1'b1);
        chk("R6 odd p=1 three ones", err_n, 0);

        for (int d = 0; d < 2; d++) begin
            for (int en = 0; en < 2; en++) begin
                for (int od = 0; od < 2; od++) begin
                    for (int v = 0; v < 256; v++) begin
                        for (int p = 0; p < 2; p++) begin
                            logic [W-1:0] bv;
                            int tot_b;
                            bit exp_err_n;
                            bv = W'((v * 37 + 11) % 256);
                            apply(d[0], en[0], od[0], W'(v), bv, p[0]);
                            tot_b = ones(bv) + p;
                            exp_err_n = ((tot_b % 2) == od);
                            // R4 generated parity sense
                            chk("R4 parity sense", 32'((ones(a_in) + int'(par_out)) % 2), 32'(od));
                            // R5
                            chk("R5 par_oe", par_oe, 32'(en == 0 && d == 1));
                            if (en == 1) begin
                                chk("R3 a_oe released", a_oe, 0);
                                chk("R3 b_oe released", b_oe, 0);
                            end else if (d == 1) begin
                                chk("R1 b_oe", b_oe, 1);
                                chk("R1 a_oe", a_oe, 0);
                                chk("R1 b_out", b_out, 32'(v));
                            end else begin
                                chk("R2 a_oe", a_oe, 1);
                                chk("R2 b_oe", b_oe, 0);
                                chk("R2 a_out", a_out, 32'(bv));
                            end
                            if (d == 1)
                                chk("R7 err_n tx", err_n, 1);
                            else if (en == 1)
                                chk("R8 err_n rx released", err_n, 32'(exp_err_n));
                            else
                                chk("R6 err_n rx", err_n, 32'(exp_err_n));
                        end
                    end
                end
            end
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end
endmodule